// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is the controller side of a synchronous serial link. Software-side logic pushes words into an eight-entry transmit queue. The engine sends each word as one frame, from 4 to 16 bits long, and during the same frame it collects a word of the same length from the serial input. The collected word goes into an eight-entry receive queue, right-justified. The engine also produces the serial clock, dividing the system clock by a programmable amount, and it drives the select / frame-sync pin.

A two-bit field selects one of three framings. The first is a plain four-wire mode with chip select, in which clock polarity and clock phase can be set. The second is a frame-sync mode, in which a one-clock-wide high pulse comes before each word. The third is a command/reply mode: the block sends an 8-bit command, waits one idle bit, then receives a reply of the programmed length. Configuration must stay unchanged while the block reports busy.

Top module: `ssp_master`

## Requirements
- R1: A frame carries N bits, MSB first, where N = `cfg_len_m1`+1. A `cfg_len_m1` value below 3 acts as 3 (N = 4). In the chip-select and frame-sync formats the bits are the low N bits of the queued word, and the master sends and receives N bits in the same frame.
- R2: The transmit queue holds 8 words. A write made while `tx_not_full` is 0 is discarded. `tx_empty` is 1 exactly when no word is waiting.
- R3: `sck` stays at its idle level outside frames. The idle level is `cfg_cpol` in the chip-select format (`cfg_format` 0 or 3). It is 0 in the frame-sync format (`cfg_format` 1) and in the command/reply format (`cfg_format` 2).
- R4: Each `sck` half-period lasts `cfg_div`+1 system clocks, so an `sck` period is 2*(`cfg_div`+1) clocks.
- R5: In the chip-select format, `sel` is low from the first clock of a frame through one idle half-period after its last edge. Between frames `sel` is high for at least one half-period. `sck` toggles only while `sel` is low.
- R6: In the chip-select format with `cfg_cpha`=0, the input is sampled on the odd `sck` edges (1, 3, …) and the output changes on the even edges. With `cfg_cpha`=1, the output changes on the odd edges after the first one and the input is sampled on the even edges.
- R7: In the frame-sync format, `sel` is high during the first `sck` period of the frame only, for 2*(`cfg_div`+1) clocks. N data periods follow. The output changes on rising edges and the input is sampled on falling edges.
- R8: In the command/reply format, `sel` is high for the whole frame. The master sends bits [7:0] of the word, MSB first, changing the output on falling edges. It then leaves one idle bit with `mosi` low and samples N reply bits on rising edges. The frame lasts (2*(N+9)+1)*(`cfg_div`+1) clocks.
- R9: The receive queue holds 8 words. `rx_data` shows the oldest word, with bits above N read as 0. `rx_rd` removes that word. `rx_rd` has no effect when the queue is empty. `rx_full` shows that all 8 entries are in use.
- R10: A word that completes while `rx_full` is 1 is dropped and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed in a cycle in which no word is dropped.
- R11: `busy` is 1 from the clock in which a frame starts until its trailing idle half-period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_format | input | 2 | 0/3 chip-select, 1 frame-sync, 2 command/reply |
| cfg_cpol | input | 1 | Idle clock level in chip-select format |
| cfg_cpha | input | 1 | Clock phase in chip-select format |
| cfg_len_m1 | input | 4 | Frame length minus one |
| cfg_div | input | 8 | Half-period length minus one, in system clocks |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit |
| rx_rd | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word |
| ovr_clr | input | 1 | Clear the overrun flag |
| tx_not_full | output | 1 | Transmit queue has room |
| tx_empty | output | 1 | Transmit queue empty |
| rx_not_empty | output | 1 | Receive queue holds a word |
| rx_full | output | 1 | Receive queue full |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky receive drop flag |
| sck | output | 1 | Serial clock |
| sel | output | 1 | Chip select / frame sync |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The embedded properties check, on every cycle, that the queue counts stay within their depth, that the chip-select format never toggles the clock while select is released, that the clock holds still between frames, and that a drop always leaves the overrun flag set until it is cleared. The bench runs a cycle-by-cycle behavioural model alongside the design. That model is the only thing that shows the bit order, the sample and change edges for each phase and format, the select pulse widths, the command/reply turnaround and the length clamp. Loopback scenarios and timed measurements of the clock period and select width add direct evidence for those points.

// File: rtl/ssp_master.sv
module ssp_master #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int DIVW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_format,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  input  logic [$clog2(W)-1:0] cfg_len_m1,
  input  logic [DIVW-1:0]      cfg_div,
  input  logic                 tx_wr,
  input  logic [W-1:0]         tx_data,
  input  logic                 rx_rd,
  output logic [W-1:0]         rx_data,
  input  logic                 ovr_clr,
  output logic                 tx_not_full,
  output logic                 tx_empty,
  output logic                 rx_not_empty,
  output logic                 rx_full,
  output logic                 busy,
  output logic                 overrun,
  output logic                 sck,
  output logic                 sel,
  output logic                 mosi,
  input  logic                 miso
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(W);
  localparam int HW = $clog2(2 * (W + 9) + 2);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0] txm [DEPTH];
  logic [W-1:0] rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;

  logic          active, gap;
  logic [HW-1:0] h;
  logic [DIVW-1:0] dcnt;
  logic [W-1:0]  sr, rsr;

  wire is_ssi = (cfg_format == 2'd1);
  wire is_mw  = (cfg_format == 2'd2);
  wire is_spi = !is_ssi && !is_mw;

  wire [LW-1:0] len_m1 = (cfg_len_m1 < LW'(3)) ? LW'(3) : cfg_len_m1;
  wire [HW-1:0] nbits  = HW'(len_m1) + HW'(1);
  wire [HW-1:0] ncyc   = is_spi ? nbits : is_ssi ? nbits + HW'(1) : nbits + HW'(9);
  wire [HW-1:0] last_h = ncyc << 1;
  wire [HW-1:0] e      = h + HW'(1);
  wire          odd    = e[0];
  wire          tick   = (dcnt == cfg_div);
  wire          idle_lvl = is_spi && cfg_cpol;
  wire [W-1:0]  mask   = ~({W{1'b1}} << nbits);

  wire sample_ev = is_spi ? (cfg_cpha ? !odd : odd)
                 : is_ssi ? (!odd && e >= HW'(4))
                 : (odd && e >= HW'(19));
  wire shift_ev  = is_spi ? (cfg_cpha ? (odd && e > HW'(1)) : !odd)
                 : is_ssi ? (odd && e >= HW'(5))
                 : (!odd && e <= HW'(16));

  wire tx_push = tx_wr && tx_not_full;
  wire tx_pop  = !active && !gap && !tx_empty;
  wire fin     = active && tick && (h == last_h);
  wire rx_push = fin && !rx_full;
  wire rx_pop  = rx_rd && rx_not_empty;

  assign tx_not_full  = tcnt < CW'(DEPTH);
  assign tx_empty     = tcnt == '0;
  assign rx_not_empty = rcnt != '0;
  assign rx_full      = rcnt == CW'(DEPTH);
  assign rx_data      = rxm[rrp];
  assign busy         = active || gap;

  assign sck  = (active && h < last_h) ? (idle_lvl ^ h[0]) : idle_lvl;
  assign sel  = is_spi ? !active : is_ssi ? (active && h < HW'(2)) : active;
  assign mosi = active && (is_mw ? (h < HW'(16) && sr[7]) : sr[len_m1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (tx_push) begin
        txm[twp] <= tx_data;
        twp <= nxt(twp);
      end
      if (tx_pop) trp <= nxt(trp);
      tcnt <= tcnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0; overrun <= 1'b0;
    end else begin
      if (rx_push) begin
        rxm[rwp] <= rsr & mask;
        rwp <= nxt(rwp);
      end
      if (rx_pop) rrp <= nxt(rrp);
      rcnt <= rcnt + CW'(rx_push) - CW'(rx_pop);
      if (fin && rx_full) overrun <= 1'b1;
      else if (ovr_clr)   overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; gap <= 1'b0; h <= '0; dcnt <= '0; sr <= '0; rsr <= '0;
    end else if (!active && !gap) begin
      dcnt <= '0;
      if (!tx_empty) begin
        active <= 1'b1;
        h      <= '0;
        sr     <= txm[trp];
        rsr    <= '0;
      end
    end else if (!tick) begin
      dcnt <= dcnt + 1'b1;
    end else begin
      dcnt <= '0;
      if (gap) gap <= 1'b0;
      else if (h == last_h) begin
        active <= 1'b0;
        gap    <= 1'b1;
      end else begin
        h <= e;
        if (sample_ev) rsr <= {rsr[W-2:0], miso};
        if (shift_ev)  sr  <= sr << 1;
      end
    end
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tcnt <= CW'(DEPTH)); // R2
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= CW'(DEPTH)); // R9
  AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_spi && sck != cfg_cpol) |-> !sel); // R5
  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cfg_cpol) && $stable(cfg_format)) |-> $stable(sck)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R10
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rx_full) |=> overrun); // R10
endmodule

// File: tb/ssp_master_tb_top.sv
module ssp_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_format = 2'd0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [3:0] cfg_len_m1 = 4'd7;
  logic [7:0] cfg_div = 8'd1;
  logic tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
  logic [15:0] tx_data = '0;
  logic [15:0] rx_data;
  logic tx_not_full, tx_empty, rx_not_empty, rx_full, busy, overrun, sck, sel, mosi, miso;
  logic loop = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign miso = loop ? mosi : lfsr[0];

  ssp_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_format(cfg_format), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_len_m1(cfg_len_m1), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .ovr_clr(ovr_clr), .tx_not_full(tx_not_full), .tx_empty(tx_empty),
    .rx_not_empty(rx_not_empty), .rx_full(rx_full), .busy(busy), .overrun(overrun),
    .sck(sck), .sel(sel), .mosi(mosi), .miso(miso));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  int ph = 0, hh = 0, dc = 0, nsh = 0, n = 4, ncy = 4, eg = 0, cy = 0;
  logic [15:0] word = '0;
  int unsigned acc = 0;
  bit m_ovr = 0, lead = 0, smp = 0, shf = 0, txf = 0, rxf = 0, rxne = 0, txne = 0, drop = 0, pend = 0;
  logic [15:0] pval = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); ph = 0; m_ovr = 0;
    end else begin
      n   = (cfg_len_m1 < 3) ? 4 : int'(cfg_len_m1) + 1;
      ncy = (cfg_format == 2'd1) ? n + 1 : (cfg_format == 2'd2) ? n + 9 : n;
      txf = txq.size() >= 8; rxf = rxq.size() >= 8;
      txne = txq.size() > 0; rxne = rxq.size() > 0;
      drop = 0; pend = 0;
      if (ph == 0) begin
        if (txne) begin word = txq.pop_front(); hh = 0; dc = 0; nsh = 0; acc = 0; ph = 1; end
      end else if (dc != int'(cfg_div)) dc++;
      else begin
        dc = 0;
        if (ph == 2) ph = 0;
        else if (hh == 2 * ncy) begin
          ph = 2;
          if (rxf) drop = 1;
          else begin pend = 1; pval = 16'(acc & ((1 << n) - 1)); end
        end else begin
          eg = hh + 1; lead = eg % 2 == 1; cy = (eg - 1) / 2;
          if (cfg_format == 2'd1)      begin smp = !lead && cy >= 1; shf = lead && cy >= 2; end
          else if (cfg_format == 2'd2) begin smp = lead && cy >= 9;  shf = !lead && cy <= 7; end
          else if (cfg_cpha)           begin smp = !lead; shf = lead && cy > 0; end
          else                         begin smp = lead;  shf = !lead; end
          if (smp) acc = (acc << 1) | int'(miso);
          if (shf) nsh++;
          hh = eg;
        end
      end
      if (rx_rd && rxne) void'(rxq.pop_front());
      if (pend) rxq.push_back(pval);
      if (drop) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
      if (tx_wr && !txf) txq.push_back(tx_data);
    end
  end

  function automatic logic exp_mosi();
    int idx;
    if (ph != 1) return 1'b0;
    if (cfg_format == 2'd2) return (hh < 16) ? word[7 - nsh] : 1'b0;
    idx = ((cfg_len_m1 < 3) ? 3 : int'(cfg_len_m1)) - nsh;
    return (idx >= 0) ? word[idx] : 1'b0;
  endfunction

  always @(posedge clk) begin
    logic idl;
    #2;
    if (rst_n && !done) begin
      idl = (cfg_format == 2'd1 || cfg_format == 2'd2) ? 1'b0 : cfg_cpol;
      chk("R3/R4 sck", 32'(sck), 32'((ph == 1 && hh < 2 * ncy) ? (idl ^ (hh % 2 == 1)) : idl));
      if (cfg_format == 2'd1)      chk("R7 sel", 32'(sel), 32'(ph == 1 && hh < 2));
      else if (cfg_format == 2'd2) chk("R8 sel", 32'(sel), 32'(ph == 1));
      else                         chk("R5 sel", 32'(sel), 32'(ph != 1));
      chk("R1 mosi", 32'(mosi), 32'(exp_mosi()));
      chk("R11 busy", 32'(busy), 32'(ph != 0));
      chk("R2 tx_not_full", 32'(tx_not_full), 32'(txq.size() < 8));
      chk("R2 tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
      chk("R9 rx_not_empty", 32'(rx_not_empty), 32'(rxq.size() > 0));
      chk("R9 rx_full", 32'(rx_full), 32'(rxq.size() == 8));
      chk("R10 overrun", 32'(overrun), 32'(m_ovr));
      if (rxq.size() > 0) chk("R9 rx_data", 32'(rx_data), 32'(rxq[0]));
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (!busy && tx_empty) break;
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] exp, input string tag);
    @(negedge clk);
    chk(tag, 32'(rx_data), 32'(exp));
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic rd_any();
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic setup(input logic [1:0] f, input logic pol, input logic pha, input logic [3:0] l, input logic [7:0] d);
    @(negedge clk); cfg_format = f; cfg_cpol = pol; cfg_cpha = pha; cfg_len_m1 = l; cfg_div = d;
  endtask

  task automatic count_sel(input logic lvl, input logic [15:0] d, output int k);
    k = 0;
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (sel == lvl) k++;
      if (!busy && tx_empty && i > 2) break;
    end
  endtask

  initial begin
    int k, p, t0;
    logic prv;
    repeat (4) @(negedge clk);
    chk("R2 reset tx_empty", 32'(tx_empty), 32'd1);
    chk("R9 reset rx_not_empty", 32'(rx_not_empty), 32'd0);
    chk("R11 reset busy", 32'(busy), 32'd0);
    chk("R3 reset sck", 32'(sck), 32'd0);
    chk("R5 reset sel", 32'(sel), 32'd1);
    chk("R10 reset overrun", 32'(overrun), 32'd0);
    rst_n = 1'b1;

    // R6 loopback, phase 0 and 1
    loop = 1'b1;
    setup(2'd0, 1'b0, 1'b0, 4'd7, 8'd1);
    wr(16'h00A5); wr(16'h003C); wr(16'h00F0);
    wait_idle();
    rd(16'h00A5, "R6 cpha0 loopback"); rd(16'h003C, "R1 loopback"); rd(16'h00F0, "R1 loopback");
    setup(2'd0, 1'b1, 1'b1, 4'd15, 8'd0);
    wr(16'hBEEF); wr(16'h1234);
    wait_idle();
    chk("R3 cpol1 idle", 32'(sck), 32'd1);
    rd(16'hBEEF, "R6 cpha1 loopback"); rd(16'h1234, "R1 16-bit");
    // R1 length clamp
    setup(2'd0, 1'b0, 1'b0, 4'd1, 8'd0);
    wr(16'hFFFF);
    wait_idle();
    rd(16'h000F, "R1 clamp / R9 zero upper");
    loop = 1'b0;

    // R4 period
    setup(2'd0, 1'b0, 1'b0, 4'd7, 8'd3);
    wr(16'h0055);
    prv = sck; t0 = 0; p = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (sck && !prv) begin
        if (t0 != 0) begin p = i - t0; break; end
        t0 = i;
      end
      prv = sck;
    end
    chk("R4 sck period", 32'(p), 32'd8);
    wait_idle(); rd_any();

    setup(2'd0, 1'b0, 1'b0, 4'd7, 8'd1);
    count_sel(1'b0, 16'h0011, k);
    chk("R5 sel low width", 32'(k), 32'd34);
    rd_any();

    // R7 frame sync
    setup(2'd1, 1'b1, 1'b0, 4'd9, 8'd2);
    chk("R3 ssi idle low", 32'(sck), 32'd0);
    count_sel(1'b1, 16'h02A7, k);
    chk("R7 fs width", 32'(k), 32'd6);
    wr(16'h0133); wr(16'h03FF);
    wait_idle();
    rd_any(); rd_any(); rd_any();

    // R8 command/reply
    setup(2'd2, 1'b1, 1'b1, 4'd11, 8'd1);
    count_sel(1'b1, 16'h00C3, k);
    chk("R8 frame width", 32'(k), 32'd86);
    wr(16'h005A); wr(16'h00FF);
    wait_idle();
    rd_any(); rd_any(); rd_any();
    rd_any();
    chk("R9 read when empty", 32'(rx_not_empty), 32'd0);

    // R2 queue full
    setup(2'd0, 1'b0, 1'b1, 4'd7, 8'd20);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin tx_wr = 1'b1; tx_data = 16'(i * 17 + 3); @(negedge clk); end
    tx_wr = 1'b0;
    chk("R2 tx full", 32'(tx_not_full), 32'd0);
    wait_idle();

    // R10 overrun: receive queue now holds 8 words
    chk("R9 rx full", 32'(rx_full), 32'd1);
    setup(2'd0, 1'b0, 1'b0, 4'd5, 8'd0);
    wr(16'h0021);
    wait_idle();
    chk("R10 overrun set", 32'(overrun), 32'd1);
    for (int i = 0; i < 8; i++) rd_any();
    chk("R10 overrun holds", 32'(overrun), 32'd1);
    @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    @(negedge clk);
    chk("R10 overrun cleared", 32'(overrun), 32'd0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R11 watchdog actual=hung expected=idle");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule